// File: doc/BRIEF.md
# Instruction Length Predecoder

This block finds instruction boundaries in a big-endian instruction byte stream where instructions can be 16, 32, 48 or 64 bits long. A fetch unit presents a window of bytes that starts at the current boundary. The block reads the major opcode from the top six bits of the first byte. While escape mode is on, the all-zero row of major opcodes selects a length class. In every other case the instruction is a plain 32-bit word.

When the window holds the whole instruction, the block takes it. It signals the take in the same cycle, together with the byte length. It advances its boundary pointer at the next clock edge, and registers a response for one cycle. The response holds the length class, the byte count, the instruction bytes left-aligned, and the 11-bit payload of the escape formats.

A variable-length block header is flagged and counted as two bytes, so that a later stage can size the block body. If the window is short, nothing is consumed and the block waits for more bytes.

Top module: `lvp_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `bnd_ptr` is 0, and `rsp_class`, `rsp_len`, `rsp_insn` and `rsp_payload` are all 0.
- R2: With `esc_en`=1, a major opcode (bits [7:2] of the first byte, which is `win_data[63:56]` for the default window) of 000000 or 000001 gives class 1 (compressed) and a length of 2 bytes.
- R3: With `esc_en`=1, a major opcode of 000010 or 000011 gives class 2 (48-bit prefixed) and a length of 6 bytes.
- R4: With `esc_en`=1, a major opcode of 000100 or 000101 gives class 3 (64-bit prefixed) and a length of 8 bytes.
- R5: With `esc_en`=1, a major opcode of 000110 or 000111 gives class 4 (block header) and a length of 2 bytes.
- R6: Every other major opcode gives class 0 (plain) and a length of 4 bytes. With `esc_en`=0, every opcode gives class 0 and a length of 4 bytes.
- R7: `take` is 1 in a cycle exactly when `win_valid`=1 and `win_avail` is at least the decoded length `take_len`. `take_len` always shows the decoded length. Without a take, `bnd_ptr` holds its value and no response is produced.
- R8: On each take, `bnd_ptr` advances by the decoded length at the clock edge, modulo 2^PTR_W.
- R9: `rsp_insn` holds the first `rsp_len` bytes of the window. The first byte is at bits [63:56]. Bytes past the length are 0.
- R10: `rsp_payload` holds the low 11 bits of the first two bytes for classes 1 to 4, and is 0 for class 0.
- R11: `rsp_valid` is 1 in the cycle after each take and 0 in the cycle after a cycle without one. The other response fields update only on a take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| esc_en | input | 1 | Escape mode enable |
| win_valid | input | 1 | Fetch window is valid |
| win_avail | input | 4 | Number of valid bytes in the window, counted from the first byte |
| win_data | input | 64 | Window bytes, first byte in the top bits |
| take | output | 1 | Instruction consumed this cycle |
| take_len | output | 4 | Decoded length in bytes |
| bnd_ptr | output | 16 | Boundary pointer |
| rsp_valid | output | 1 | Response valid |
| rsp_class | output | 3 | Length class of the response |
| rsp_len | output | 4 | Byte length of the response |
| rsp_insn | output | 64 | Aligned instruction bytes, zero-padded |
| rsp_payload | output | 11 | Payload bits of the escape formats |

## Verification
The hardest case to reach is a window that holds fewer bytes than the decoded length. Only then must the block refuse the instruction and leave the pointer in place. A table of vectors sets `win_avail` one below and exactly at each length, with escape mode both on and off. A directed stream test keeps the pointer and the window in step: it serves the window from a byte array at the current `bnd_ptr`. Instructions of mixed length then follow each other back to back, and the stream ends with a short tail.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  localparam int MAX_INSN_BYTES = 8;
  localparam int LEN_W          = 4;
  localparam int PAYLOAD_W      = 11;

  typedef enum logic [2:0] {
    LC_PLAIN32 = 3'd0,
    LC_C16     = 3'd1,
    LC_P48     = 3'd2,
    LC_P64     = 3'd3,
    LC_VBLK    = 3'd4
  } len_class_e;

  // Length class from the first byte; the escape row is major opcode 000xxx.
  function automatic len_class_e f_class(input logic [7:0] b0, input logic esc);
    len_class_e c;
    c = LC_PLAIN32;
    if (esc && (b0[7:5] == 3'b000)) begin
      unique case (b0[4:3])
        2'b00:   c = LC_C16;
        2'b01:   c = LC_P48;
        2'b10:   c = LC_P64;
        default: c = LC_VBLK;
      endcase
    end
    return c;
  endfunction

  function automatic logic [LEN_W-1:0] f_len(input len_class_e c);
    logic [LEN_W-1:0] n;
    unique case (c)
      LC_C16:  n = 4'd2;
      LC_P48:  n = 4'd6;
      LC_P64:  n = 4'd8;
      LC_VBLK: n = 4'd2;
      default: n = 4'd4;
    endcase
    return n;
  endfunction

  function automatic logic [PAYLOAD_W-1:0] f_payload(input logic [15:0] hdr,
                                                     input len_class_e c);
    return (c == LC_PLAIN32) ? '0 : hdr[PAYLOAD_W-1:0];
  endfunction

endpackage

// File: rtl/lvp_classify.sv
module lvp_classify
  import lvp_pkg::*;
(
  input  logic [15:0]          hdr,
  input  logic                 esc_en,
  output len_class_e           cls,
  output logic [LEN_W-1:0]     len,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 is_escape
);

  always_comb begin
    cls       = f_class(hdr[15:8], esc_en);
    len       = f_len(cls);
    payload   = f_payload(hdr, cls);
    is_escape = (cls != LC_PLAIN32);
  end

endmodule

// File: rtl/lvp_align.sv
module lvp_align
  import lvp_pkg::*;
#(
  parameter int WIN_BYTES = 8
) (
  input  logic [8*WIN_BYTES-1:0]    win_data,
  input  logic [LEN_W-1:0]          len,
  output logic [8*MAX_INSN_BYTES-1:0] insn
);

  localparam int WIN_W = 8 * WIN_BYTES;
  localparam int OUT_W = 8 * MAX_INSN_BYTES;

  for (genvar i = 0; i < MAX_INSN_BYTES; i++) begin : g_byte
    logic       keep;
    logic [7:0] src;
    assign src  = win_data[WIN_W-1-8*i -: 8];
    assign keep = (len > LEN_W'(i));
    assign insn[OUT_W-1-8*i -: 8] = keep ? src : 8'h00;
  end

endmodule

// File: rtl/lvp_ptr.sv
module lvp_ptr
  import lvp_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LEN_W-1:0] step,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_nxt;

  always_comb ptr_nxt = ptr + PTR_W'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

endmodule

// File: rtl/lvp_top.sv
module lvp_top
  import lvp_pkg::*;
#(
  parameter int WIN_BYTES = 8,
  parameter int PTR_W     = 16,
  localparam int AVAIL_W  = $clog2(WIN_BYTES + 1),
  localparam int WIN_W    = 8 * WIN_BYTES,
  localparam int INSN_W   = 8 * MAX_INSN_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 esc_en,
  input  logic                 win_valid,
  input  logic [AVAIL_W-1:0]   win_avail,
  input  logic [WIN_W-1:0]     win_data,
  output logic                 take,
  output logic [LEN_W-1:0]     take_len,
  output logic [PTR_W-1:0]     bnd_ptr,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_class,
  output logic [LEN_W-1:0]     rsp_len,
  output logic [INSN_W-1:0]    rsp_insn,
  output logic [PAYLOAD_W-1:0] rsp_payload
);

  // Named internal events for the checker.
  len_class_e           dec_cls;
  logic [PAYLOAD_W-1:0] dec_payload;
  logic                 dec_escape;
  logic [INSN_W-1:0]    dec_insn;
  logic                 win_short;

  len_class_e           cls_q;

  lvp_classify u_cls (
    .hdr       (win_data[WIN_W-1 -: 16]),
    .esc_en    (esc_en),
    .cls       (dec_cls),
    .len       (take_len),
    .payload   (dec_payload),
    .is_escape (dec_escape)
  );

  lvp_align #(.WIN_BYTES(WIN_BYTES)) u_align (
    .win_data (win_data),
    .len      (take_len),
    .insn     (dec_insn)
  );

  always_comb begin
    win_short = (int'(win_avail) < int'(take_len));
    take      = win_valid && !win_short;
  end

  lvp_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .step  (take_len),
    .ptr   (bnd_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      cls_q       <= LC_PLAIN32;
      rsp_len     <= '0;
      rsp_insn    <= '0;
      rsp_payload <= '0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        cls_q       <= dec_cls;
        rsp_len     <= take_len;
        rsp_insn    <= dec_insn;
        rsp_payload <= dec_payload;
      end
    end
  end

  assign rsp_class = cls_q;

endmodule

// File: rtl/lvp_chk.sv
module lvp_chk
  import lvp_pkg::*;
#(
  parameter int WIN_BYTES = 8,
  parameter int PTR_W     = 16,
  localparam int AVAIL_W  = $clog2(WIN_BYTES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 esc_en,
  input logic                 win_valid,
  input logic [AVAIL_W-1:0]   win_avail,
  input logic                 take,
  input logic [LEN_W-1:0]     take_len,
  input logic [PTR_W-1:0]     bnd_ptr,
  input logic                 rsp_valid,
  input logic [2:0]           rsp_class,
  input logic [LEN_W-1:0]     rsp_len,
  input logic [63:0]          rsp_insn,
  input logic [PAYLOAD_W-1:0] rsp_payload
);

  assert_take_needs_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (win_valid && (int'(win_avail) >= int'(take_len))));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(bnd_ptr));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bnd_ptr == PTR_W'($past(bnd_ptr) + PTR_W'($past(take_len)))));

  assert_rsp_follows_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rsp_valid);

  assert_plain_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !esc_en) |=> (rsp_class == 3'd0 && rsp_len == 4'd4));

  assert_short_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 3'd1) |-> rsp_len == 4'd2);

  assert_p48_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 3'd2) |-> rsp_len == 4'd6);

  assert_p64_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 3'd3) |-> rsp_len == 4'd8);

  assert_vblk_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 3'd4) |-> rsp_len == 4'd2);

  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_len == 4'd2) |-> rsp_insn[47:0] == 48'h0);

  assert_plain_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 3'd0) |-> rsp_payload == '0);

endmodule

bind lvp_top lvp_chk #(.WIN_BYTES(WIN_BYTES), .PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .esc_en      (esc_en),
  .win_valid   (win_valid),
  .win_avail   (win_avail),
  .take        (take),
  .take_len    (take_len),
  .bnd_ptr     (bnd_ptr),
  .rsp_valid   (rsp_valid),
  .rsp_class   (rsp_class),
  .rsp_len     (rsp_len),
  .rsp_insn    (rsp_insn),
  .rsp_payload (rsp_payload)
);

// File: tb/tb_lvp_top.sv
module tb_lvp_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        esc_en = 1'b0;
  logic        win_valid = 1'b0;
  logic [3:0]  win_avail = '0;
  logic [63:0] win_data = '0;
  logic        take;
  logic [3:0]  take_len;
  logic [15:0] bnd_ptr;
  logic        rsp_valid;
  logic [2:0]  rsp_class;
  logic [3:0]  rsp_len;
  logic [63:0] rsp_insn;
  logic [10:0] rsp_payload;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_ptr = '0;

  always #5 clk = ~clk;

  lvp_top dut (
    .clk(clk), .rst_n(rst_n), .esc_en(esc_en), .win_valid(win_valid),
    .win_avail(win_avail), .win_data(win_data), .take(take), .take_len(take_len),
    .bnd_ptr(bnd_ptr), .rsp_valid(rsp_valid), .rsp_class(rsp_class),
    .rsp_len(rsp_len), .rsp_insn(rsp_insn), .rsp_payload(rsp_payload)
  );

  typedef struct packed {
    logic        esc;
    logic [3:0]  avail;
    logic [63:0] win;
    logic [2:0]  cls;
    logic [3:0]  len;
    logic        tk;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd8, 64'h00AB_1122_3344_5566, 3'd1, 4'd2, 1'b1},
    '{1'b1, 4'd8, 64'h07FF_0102_0304_0506, 3'd1, 4'd2, 1'b1},
    '{1'b1, 4'd8, 64'h04C0_0102_0304_0506, 3'd1, 4'd2, 1'b1},
    '{1'b1, 4'd8, 64'h0812_3456_789A_BCDE, 3'd2, 4'd6, 1'b1},
    '{1'b1, 4'd8, 64'h0F00_A1A2_A3A4_A5A6, 3'd2, 4'd6, 1'b1},
    '{1'b1, 4'd8, 64'h1034_5678_9ABC_DEF0, 3'd3, 4'd8, 1'b1},
    '{1'b1, 4'd8, 64'h17C3_0011_2233_4455, 3'd3, 4'd8, 1'b1},
    '{1'b1, 4'd8, 64'h1855_6677_8899_AABB, 3'd4, 4'd2, 1'b1},
    '{1'b1, 4'd8, 64'h1F01_0203_0405_0607, 3'd4, 4'd2, 1'b1},
    '{1'b1, 4'd8, 64'h2001_0203_0405_0607, 3'd0, 4'd4, 1'b1},
    '{1'b1, 4'd8, 64'h4011_2233_4455_6677, 3'd0, 4'd4, 1'b1},
    '{1'b1, 4'd8, 64'hFC10_2030_4050_6070, 3'd0, 4'd4, 1'b1},
    '{1'b0, 4'd8, 64'h0011_2233_4455_6677, 3'd0, 4'd4, 1'b1},
    '{1'b0, 4'd8, 64'h1011_2233_4455_6677, 3'd0, 4'd4, 1'b1},
    '{1'b0, 4'd8, 64'h1811_2233_4455_6677, 3'd0, 4'd4, 1'b1},
    '{1'b1, 4'd7, 64'h1011_2233_4455_6677, 3'd3, 4'd8, 1'b0},
    '{1'b1, 4'd6, 64'h0811_2233_4455_6677, 3'd2, 4'd6, 1'b1},
    '{1'b1, 4'd5, 64'h0811_2233_4455_6677, 3'd2, 4'd6, 1'b0},
    '{1'b1, 4'd1, 64'h0011_2233_4455_6677, 3'd1, 4'd2, 1'b0},
    '{1'b1, 4'd2, 64'h0011_2233_4455_6677, 3'd1, 4'd2, 1'b1},
    '{1'b0, 4'd3, 64'h0811_2233_4455_6677, 3'd0, 4'd4, 1'b0},
    '{1'b0, 4'd4, 64'h0811_2233_4455_6677, 3'd0, 4'd4, 1'b1}
  };

  function automatic logic [63:0] exp_insn(input logic [63:0] w, input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      r = r << 8;
      if (k < n) r[7:0] = w[63-8*k -: 8];
    end
    return r;
  endfunction

  function automatic logic [10:0] exp_payload(input logic [63:0] w, input logic [2:0] c);
    if (c == 3'd0) return 11'd0;
    return w[58:48];
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one window, check the same-cycle take, then the response after the edge.
  task automatic run_vec(input logic esc, input logic vld, input logic [3:0] av,
                         input logic [63:0] w, input logic [2:0] ecls,
                         input logic [3:0] elen, input logic etk);
    string rq;
    rq = req_of(ecls);
    @(negedge clk);
    esc_en = esc; win_valid = vld; win_avail = av; win_data = w;
    #1;
    chk(take_len == elen, rq, "take_len", 64'(take_len), 64'(elen));
    chk(take == etk, "R7", "take", 64'(take), 64'(etk));
    @(posedge clk);
    #1;
    if (etk) begin
      exp_ptr = exp_ptr + 16'(elen);
      chk(rsp_valid == 1'b1, "R11", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_class == ecls, rq, "rsp_class", 64'(rsp_class), 64'(ecls));
      chk(rsp_len == elen, rq, "rsp_len", 64'(rsp_len), 64'(elen));
      chk(rsp_insn == exp_insn(w, int'(elen)), "R9", "rsp_insn", rsp_insn,
          exp_insn(w, int'(elen)));
      chk(rsp_payload == exp_payload(w, ecls), "R10", "rsp_payload",
          64'(rsp_payload), 64'(exp_payload(w, ecls)));
      chk(bnd_ptr == exp_ptr, "R8", "bnd_ptr", 64'(bnd_ptr), 64'(exp_ptr));
    end else begin
      chk(rsp_valid == 1'b0, "R11", "rsp_valid idle", 64'(rsp_valid), 64'd0);
      chk(bnd_ptr == exp_ptr, "R7", "bnd_ptr hold", 64'(bnd_ptr), 64'(exp_ptr));
    end
  endtask

  // Stream of mixed lengths: C16, plain, P48, P64, block header, plain.
  localparam int SLEN = 26;
  logic [7:0] stream [SLEN] = '{
    8'h00, 8'h11,
    8'h40, 8'h00, 8'h00, 8'h01,
    8'h08, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE,
    8'h10, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
    8'h18, 8'h22,
    8'hFC, 8'h01, 8'h02, 8'h03
  };
  localparam logic [3:0] SL [6] = '{4'd2, 4'd4, 4'd6, 4'd8, 4'd2, 4'd4};
  localparam logic [2:0] SC [6] = '{3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 3'd0};

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] base;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk(bnd_ptr == 16'd0, "R1", "bnd_ptr", 64'(bnd_ptr), 64'd0);
    chk(rsp_class == 3'd0 && rsp_len == 4'd0, "R1", "class/len",
        64'({rsp_class, rsp_len}), 64'd0);
    chk(rsp_insn == 64'd0 && rsp_payload == 11'd0, "R1", "insn/payload",
        rsp_insn, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i].esc, 1'b1, VECS[i].avail, VECS[i].win,
              VECS[i].cls, VECS[i].len, VECS[i].tk);

    // R7: invalid window is never taken, even when full
    run_vec(1'b1, 1'b0, 4'd8, 64'h0812_3456_789A_BCDE, 3'd2, 4'd6, 1'b0);

    // R11: response fields hold through an idle cycle
    run_vec(1'b1, 1'b1, 4'd8, 64'h1855_6677_8899_AABB, 3'd4, 4'd2, 1'b1);
    run_vec(1'b1, 1'b1, 4'd3, 64'h1034_5678_9ABC_DEF0, 3'd3, 4'd8, 1'b0);
    chk(rsp_class == 3'd4 && rsp_len == 4'd2, "R11", "held class/len",
        64'({rsp_class, rsp_len}), 64'h42);

    // R8: back-to-back stream served from the pointer
    base = bnd_ptr;
    for (int s = 0; s < 6; s++) begin
      int off;
      int av;
      logic [63:0] w;
      off = int'(bnd_ptr - base);
      av = (SLEN - off > 8) ? 8 : SLEN - off;
      w = '0;
      for (int k = 0; k < 8; k++)
        if (k < av) w[63-8*k -: 8] = stream[off+k];
      run_vec(1'b1, 1'b1, 4'(av), w, SC[s], SL[s], 1'b1);
    end
    chk(bnd_ptr - base == 16'(SLEN), "R8", "stream end", 64'(bnd_ptr - base),
        64'(SLEN));

    // R7: empty tail window stalls
    run_vec(1'b1, 1'b1, 4'd0, 64'h0, 3'd1, 4'd2, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule